// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block applies gamma correction to three independent display channels. Each channel owns three 256-entry tables of 8-bit values, one per colour component. Every clock, each channel takes in one 24-bit pixel. If that channel's gamma is enabled, each component is replaced by the table entry it indexes. If gamma is disabled, the pixel passes through unchanged. The horizontal sync, vertical sync and data-enable strobes travel through the same single register stage, so they stay aligned with the pixel.

Software fills the tables through two registers. An address register holds a word address and two control bits. A data port stores one byte at that address, and it can step the address forward after each write. All tables share one word address space. The space is ordered by channel first. Within a channel the order is red, then green, then blue.

The table storage is powered only while at least one channel has gamma enabled, or while a keep-powered bit is set. When power is removed, every entry is lost and reads back as zero.

Top module: `gamma_lut`

## Requirements
- R1: The word address of an entry is channel×768 + component×256 + index, where component 0 is red, 1 is green and 2 is blue. In each 24-bit pixel, red is bits [23:16], green is [15:8] and blue is [7:0]. Channel c uses bits [24c+23:24c] of the pixel buses.
- R2: A register write with `cfg_sel`=0 loads the address register. Bits [11:0] become the word address, bit 31 enables auto-increment and bit 30 sets keep-powered.
- R3: A register write with `cfg_sel`=1 stores `cfg_wdata[7:0]` at the current address. With auto-increment on, the address then advances by one. With auto-increment off, the address holds.
- R4: A data write to an address of 2304 or above changes no entry. The address still advances when auto-increment is on.
- R5: A channel whose `gamma_en` bit is 1 outputs, one clock later, the three table entries selected by its input components.
- R6: A channel whose `gamma_en` bit is 0 outputs its input pixel unchanged, one clock later.
- R7: For each channel, `hs_out`, `vs_out` and `de_out` equal the matching inputs from one clock earlier.
- R8: At any clock edge where every `gamma_en` bit is 0 and keep-powered is clear, all entries become zero. A data write in that cycle is dropped.
- R9: While keep-powered is set, table contents survive periods with every channel's gamma disabled.
- R10: After reset, the outputs are zero, every entry reads zero, the address is 0, and auto-increment and keep-powered are off.
- R11: A lookup of an entry in the same cycle that entry is written returns the old value. The new value is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the address register, 1 selects the data port |
| cfg_wdata | input | 32 | Register write data |
| gamma_en | input | 3 | Per-channel gamma enable |
| pix_in | input | 72 | Input pixels, 24 bits per channel |
| hs_in | input | 3 | Per-channel horizontal sync in |
| vs_in | input | 3 | Per-channel vertical sync in |
| de_in | input | 3 | Per-channel data enable in |
| pix_out | output | 72 | Corrected or bypassed pixels |
| hs_out | output | 3 | Delayed horizontal sync |
| vs_out | output | 3 | Delayed vertical sync |
| de_out | output | 3 | Delayed data enable |

## Verification
Every output is due exactly one clock after the inputs that produce it. A table write, an address update or a power-down takes effect at the edge where it is presented, so it first shows up in lookups presented on the following cycle. The bench drives inputs on the falling edge. On the next falling edge it compares all outputs against values its model computed from the state it held before that edge. After making that prediction, the model applies the edge's writes and clears.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  typedef enum int {COMP_RED = 0, COMP_GREEN = 1, COMP_BLUE = 2} comp_e;

  localparam int COMPS = 3;
  localparam int CFG_W = 32;
  localparam int AUTOINC_BIT = 31;
  localparam int KEEP_ON_BIT = 30;

  // table number inside the shared word space
  function automatic int tbl_index(int ch, int comp);
    return ch * COMPS + comp;
  endfunction

  // least significant bit of a component inside one pixel
  function automatic int comp_lsb(int comp, int cw);
    return (COMPS - 1 - comp) * cw;
  endfunction

  function automatic bit word_in_range(int unsigned addr, int unsigned words);
    return addr < words;
  endfunction

endpackage

// File: rtl/gamma_lut_regs.sv
module gamma_lut_regs
  import gamma_lut_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORDS  = 2304
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              mem_on,
  output logic [ADDR_W-1:0] addr_q,
  output logic              autoinc_q,
  output logic              keep_on_q,
  output logic              data_we
);

  logic addr_wr, data_wr;
  assign addr_wr = cfg_wr && !cfg_sel;
  assign data_wr = cfg_wr && cfg_sel;

  assign data_we = data_wr && mem_on && word_in_range(int'(addr_q), WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      autoinc_q <= 1'b0;
      keep_on_q <= 1'b0;
    end else if (addr_wr) begin
      addr_q    <= cfg_wdata[ADDR_W-1:0];
      autoinc_q <= cfg_wdata[AUTOINC_BIT];
      keep_on_q <= cfg_wdata[KEEP_ON_BIT];
    end else if (data_wr && autoinc_q) begin
      addr_q <= addr_q + 1'b1;
    end
  end

endmodule

// File: rtl/gamma_lut_table.sv
module gamma_lut_table #(
  parameter int CW = 8,
  localparam int DEPTH = 1 << CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          we,
  input  logic [CW-1:0] widx,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] ridx,
  output logic [CW-1:0] rdata
);

  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clear) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/gamma_lut_chan.sv
module gamma_lut_chan
  import gamma_lut_pkg::*;
#(
  parameter int CW     = 8,
  parameter int TSEL_W = 4,
  parameter int CH     = 0,
  localparam int PIX_W = COMPS * CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              we,
  input  logic [TSEL_W-1:0] wsel,
  input  logic [CW-1:0]     widx,
  input  logic [CW-1:0]     wdata,
  input  logic              en,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              de_in,
  output logic [PIX_W-1:0]  pix_out,
  output logic              hs_out,
  output logic              vs_out,
  output logic              de_out
);

  logic [PIX_W-1:0] lut_pix;

  for (genvar k = 0; k < COMPS; k++) begin : g_comp
    localparam int LSB = comp_lsb(k, CW);
    logic tbl_we;
    assign tbl_we = we && (wsel == TSEL_W'(tbl_index(CH, k)));

    gamma_lut_table #(.CW(CW)) table_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .we    (tbl_we),
      .widx  (widx),
      .wdata (wdata),
      .ridx  (pix_in[LSB +: CW]),
      .rdata (lut_pix[LSB +: CW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out <= '0;
      hs_out  <= 1'b0;
      vs_out  <= 1'b0;
      de_out  <= 1'b0;
    end else begin
      pix_out <= en ? lut_pix : pix_in;
      hs_out  <= hs_in;
      vs_out  <= vs_in;
      de_out  <= de_in;
    end
  end

endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 8,
  localparam int DEPTH  = 1 << CW,
  localparam int PIX_W  = COMPS * CW,
  localparam int WORDS  = NCH * COMPS * DEPTH,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int TSEL_W = ADDR_W - CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_sel,
  input  logic [31:0]        cfg_wdata,
  input  logic [NCH-1:0]     gamma_en,
  input  logic [NCH*PIX_W-1:0] pix_in,
  input  logic [NCH-1:0]     hs_in,
  input  logic [NCH-1:0]     vs_in,
  input  logic [NCH-1:0]     de_in,
  output logic [NCH*PIX_W-1:0] pix_out,
  output logic [NCH-1:0]     hs_out,
  output logic [NCH-1:0]     vs_out,
  output logic [NCH-1:0]     de_out
);

  // named internal events, observed by the bound checker
  logic [ADDR_W-1:0] addr_q;
  logic              autoinc_q;
  logic              keep_on_q;
  logic              mem_on;
  logic              tbl_we;

  assign mem_on = (|gamma_en) || keep_on_q;

  gamma_lut_regs #(.ADDR_W(ADDR_W), .WORDS(WORDS)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .mem_on    (mem_on),
    .addr_q    (addr_q),
    .autoinc_q (autoinc_q),
    .keep_on_q (keep_on_q),
    .data_we   (tbl_we)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gamma_lut_chan #(.CW(CW), .TSEL_W(TSEL_W), .CH(c)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!mem_on),
      .we      (tbl_we),
      .wsel    (addr_q[ADDR_W-1:CW]),
      .widx    (addr_q[CW-1:0]),
      .wdata   (cfg_wdata[CW-1:0]),
      .en      (gamma_en[c]),
      .pix_in  (pix_in[c*PIX_W +: PIX_W]),
      .hs_in   (hs_in[c]),
      .vs_in   (vs_in[c]),
      .de_in   (de_in[c]),
      .pix_out (pix_out[c*PIX_W +: PIX_W]),
      .hs_out  (hs_out[c]),
      .vs_out  (vs_out[c]),
      .de_out  (de_out[c])
    );
  end

endmodule

// File: rtl/gamma_lut_sva.sv
module gamma_lut_sva #(
  parameter int NCH    = 3,
  parameter int CW     = 8,
  parameter int ADDR_W = 12,
  localparam int PIX_W = 3 * CW,
  localparam int WORDS = NCH * 3 * (1 << CW)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr,
  input logic                 cfg_sel,
  input logic [NCH-1:0]       gamma_en,
  input logic [NCH*PIX_W-1:0] pix_in,
  input logic [NCH-1:0]       hs_in,
  input logic [NCH-1:0]       vs_in,
  input logic [NCH-1:0]       de_in,
  input logic [NCH*PIX_W-1:0] pix_out,
  input logic [NCH-1:0]       hs_out,
  input logic [NCH-1:0]       vs_out,
  input logic [NCH-1:0]       de_out,
  input logic [ADDR_W-1:0]    addr_q,
  input logic                 autoinc_q,
  input logic                 mem_on,
  input logic                 tbl_we
);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (hs_out == $past(hs_in)) && (vs_out == $past(vs_in)) && (de_out == $past(de_in)))
    else $error("a_r7_sync_delay");

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(gamma_en[c])) |->
        pix_out[c*PIX_W +: PIX_W] == $past(pix_in[c*PIX_W +: PIX_W]))
      else $error("a_r6_bypass ch%0d", c);
  end

  a_r3_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(cfg_wr && cfg_sel && autoinc_q)) |->
      addr_q == ADDR_W'($past(addr_q) + 1'b1))
    else $error("a_r3_autoinc");

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(cfg_wr && cfg_sel && !autoinc_q)) |-> $stable(addr_q))
    else $error("a_r3_hold");

  a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> ({1'b0, addr_q} < (ADDR_W+1)'(WORDS)))
    else $error("a_r4_range");

  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_on |-> !tbl_we)
    else $error("a_r8_drop");

endmodule

bind gamma_lut gamma_lut_sva #(.NCH(NCH), .CW(CW), .ADDR_W(ADDR_W)) sva_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_sel  (cfg_sel),
  .gamma_en (gamma_en),
  .pix_in   (pix_in),
  .hs_in    (hs_in),
  .vs_in    (vs_in),
  .de_in    (de_in),
  .pix_out  (pix_out),
  .hs_out   (hs_out),
  .vs_out   (vs_out),
  .de_out   (de_out),
  .addr_q   (addr_q),
  .autoinc_q(autoinc_q),
  .mem_on   (mem_on),
  .tbl_we   (tbl_we)
);

// File: tb/gamma_lut_tb_top.sv
`timescale 1ns/1ps
module gamma_lut_tb_top;

  localparam int NCH   = 3;
  localparam int PW    = 24;
  localparam int WORDS = 2304;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [NCH-1:0] gamma_en = '0;
  logic [NCH*PW-1:0] pix_in = '0;
  logic [NCH-1:0] hs_in = '0, vs_in = '0, de_in = '0;
  logic [NCH*PW-1:0] pix_out;
  logic [NCH-1:0] hs_out, vs_out, de_out;

  always #2.5 clk = ~clk;

  gamma_lut dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .gamma_en(gamma_en), .pix_in(pix_in),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in), .pix_out(pix_out),
    .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out)
  );

  // reference state
  int mem [WORDS];
  int m_addr;
  bit m_ai, m_keep;
  logic [NCH*PW-1:0] exp_pix;
  logic [NCH-1:0] exp_hs, exp_vs, exp_de, exp_en;
  string ph_prev;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  // next inputs
  logic n_wr, n_sel;
  logic [31:0] n_wd;
  logic [NCH-1:0] n_en;
  logic [NCH*PW-1:0] n_pix;

  task automatic check_outputs();
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (pix_out[c*PW +: PW] !== exp_pix[c*PW +: PW]) begin
        errors++;
        $display("FAIL %s [%s] ch%0d pixel actual=%h expected=%h",
                 exp_en[c] ? "R5" : "R6", ph_prev, c, pix_out[c*PW +: PW], exp_pix[c*PW +: PW]);
      end
    end
    checks++;
    if ({hs_out, vs_out, de_out} !== {exp_hs, exp_vs, exp_de}) begin
      errors++;
      $display("FAIL R7 [%s] syncs actual=%h expected=%h", ph_prev,
               {hs_out, vs_out, de_out}, {exp_hs, exp_vs, exp_de});
    end
  endtask

  function automatic logic [PW-1:0] look(int c, logic [PW-1:0] p);
    logic [PW-1:0] r;
    for (int k = 0; k < 3; k++)
      r[(2-k)*8 +: 8] = 8'(mem[(c*3 + k)*256 + int'(p[(2-k)*8 +: 8])]);
    return r;
  endfunction

  task automatic tick(string ph);
    logic [NCH-1:0] hs, vs, de;
    bit on;
    @(negedge clk);
    check_outputs();
    hs = NCH'($urandom); vs = NCH'($urandom); de = NCH'($urandom);
    cfg_wr = n_wr; cfg_sel = n_sel; cfg_wdata = n_wd;
    gamma_en = n_en; pix_in = n_pix; hs_in = hs; vs_in = vs; de_in = de;
    for (int c = 0; c < NCH; c++)
      exp_pix[c*PW +: PW] = n_en[c] ? look(c, n_pix[c*PW +: PW]) : n_pix[c*PW +: PW];
    exp_hs = hs; exp_vs = vs; exp_de = de; exp_en = n_en;
    on = (n_en != 0) || m_keep;
    if (!on) for (int i = 0; i < WORDS; i++) mem[i] = 0;
    if (n_wr && !n_sel) begin
      m_addr = int'(n_wd[11:0]); m_ai = n_wd[31]; m_keep = n_wd[30];
    end else if (n_wr && n_sel) begin
      if (on && m_addr < WORDS) mem[m_addr] = int'(n_wd[7:0]);
      if (m_ai) m_addr = (m_addr + 1) % 4096;
    end
    ph_prev = ph;
    n_wr = 1'b0;
  endtask

  function automatic logic [NCH*PW-1:0] rnd_pix();
    return (NCH*PW)'({$urandom, $urandom, $urandom});
  endfunction

  task automatic reg_wr(logic sel, logic [31:0] d, string ph);
    n_wr = 1'b1; n_sel = sel; n_wd = d; n_pix = rnd_pix();
    tick(ph);
  endtask

  task automatic lookups(int n, bit any_en, string ph);
    for (int i = 0; i < n; i++) begin
      n_pix = rnd_pix();
      if (any_en) n_en = NCH'(1 + $urandom % 7);
      tick(ph);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 0;
    m_addr = 0; m_ai = 0; m_keep = 0;
    exp_pix = '0; exp_hs = '0; exp_vs = '0; exp_de = '0; exp_en = '0;
    ph_prev = "R10 reset";
    n_wr = 0; n_sel = 0; n_wd = '0; n_en = '0; n_pix = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10: outputs zero, then all entries read zero
    n_en = '1;
    lookups(20, 1'b0, "R10 zeros after reset");
    // R1 R2 R3: fill every table through the auto-incrementing port
    reg_wr(1'b0, 32'h8000_0000, "R2 addr");
    for (int w = 0; w < WORDS; w++) reg_wr(1'b1, 32'((w * 37 + 11) & 255), "R1 R3 load");
    lookups(400, 1'b1, "R1 R5 R6 lookup");
    // R3: no auto-increment, second write lands on the same entry
    n_en = '1;
    reg_wr(1'b0, 32'h0000_0100, "R2 addr");
    reg_wr(1'b1, 32'hAA, "R3 hold");
    reg_wr(1'b1, 32'hBB, "R3 hold");
    n_pix = '0; tick("R3 hold check");
    // R4: out-of-range writes are dropped
    reg_wr(1'b0, 32'h8000_08FF, "R2 addr");
    reg_wr(1'b1, 32'h11, "R4");
    reg_wr(1'b1, 32'h22, "R4");
    reg_wr(1'b1, 32'h33, "R4");
    n_pix = {24'h0000FF, 24'hFFFFFF, 24'hFFFFFF}; tick("R4 check");
    lookups(30, 1'b1, "R4 lookup");
    // R11: lookup coincident with a write of the same entry
    n_en = '1;
    reg_wr(1'b0, 32'h8000_0005, "R2 addr");
    n_wr = 1'b1; n_sel = 1'b1; n_wd = 32'h77; n_pix = {48'h0, 24'h050505};
    tick("R11 same cycle");
    n_pix = {48'h0, 24'h050505}; tick("R11 next cycle");
    // R9: keep-powered holds contents across all-disabled
    reg_wr(1'b0, 32'h4000_0000, "R2 keep");
    n_en = '0;
    lookups(8, 1'b0, "R9 R6 disabled");
    lookups(60, 1'b1, "R9 retained");
    // R8: power-down clears the tables and drops writes
    n_en = '1;
    reg_wr(1'b0, 32'h8000_0000, "R2 release");
    n_en = '0;
    lookups(4, 1'b0, "R8 off");
    reg_wr(1'b1, 32'h99, "R8 dropped write");
    lookups(4, 1'b0, "R8 off");
    lookups(60, 1'b1, "R8 cleared");
    n_en = '1;
    for (int w = 0; w < 8; w++) reg_wr(1'b1, 32'(200 + w), "R3 reload");
    n_pix = {24'h010203, 24'h040506, 24'h000000}; tick("R3 reload check");
    lookups(30, 1'b1, "R5 final");
    n_en = '0; n_pix = '0;
    tick("R6 final");
    @(negedge clk); check_outputs();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule